// File: doc/BRIEF.md
# Watchdog Timer With Frequency Revert

This block guards frequency changes made by firmware. Software sets a 4-bit timeout code and, while the new operating point is tried, pulses a reload bit to show it is still alive. The count advances on a millisecond strobe from outside the block. If the count reaches the selected limit before a reload, the block raises an alarm flag and drives an active-low system reset for a fixed number of ticks. It also replaces the active frequency code with a fallback code, so the system restarts at a setting known to work.

The fallback code is either the code latched from the board straps or the software frequency code as it stands at the moment of expiry. A recovery-select input picks between them. When no expiry has happened, an override input picks the active code: the strap code or the software code. The block only produces the 4-bit code and a one-cycle revert strobe. Frequency synthesis is done elsewhere.

Top module: `wdt_freq_guard`

## Requirements
- R1: After reset, `alarm` is 0, `sys_rst_n` is 1, `revert_pulse` is 0 and `freq_code` follows the normal selection of R9.
- R2: With `tmo_sel` = 4'b0000 the watchdog is disabled, and no number of ticks causes an expiry.
- R3: Code 4'b0001 gives a limit of FAST_TIMEOUT_TICKS ticks. Codes 4'b0010 to 4'b1111 give a limit of 2 × code × TICKS_PER_SEC ticks. Expiry happens on the clock edge that accepts the limit-th tick after the count restarted. A tick in a restart cycle is not counted.
- R4: `alarm` rises on expiry and stays 1 while `tmo_sel` is nonzero, even with further ticks. It clears on the first edge at which `tmo_sel` is 4'b0000.
- R5: A 0-to-1 change of `reload` restarts the count from zero and the timer keeps running. Holding `reload` at 1 has no further effect.
- R6: A change of `tmo_sel` to any nonzero value restarts the count, which then runs against the new limit.
- R7: From the expiry edge, `sys_rst_n` is 0 until RESET_TICKS further ticks have been accepted. Cycles without a tick do not shorten the pulse.
- R8: On expiry the fallback code is captured: `strap_code` if `recover_sw` is 0, `sw_code` if it is 1. While `alarm` is 1, `freq_code` holds that captured code whatever the inputs do. `revert_pulse` is 1 for exactly the one cycle after the expiry edge.
- R9: While `alarm` is 0, `freq_code` equals `sw_code` when `fs_override` is 1 and `strap_code` when it is 0.
- R10: If a reload rising edge and the limit-th tick fall in the same cycle, the restart wins and no expiry occurs.
- R11: The count advances only in cycles with `ms_tick` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle millisecond strobe |
| tmo_sel | input | 4 | Timeout code; 0 disables the watchdog and clears the alarm |
| reload | input | 1 | Restart request, acting on its rising edge |
| recover_sw | input | 1 | Fallback source: 0 = strap code, 1 = software code |
| fs_override | input | 1 | Normal source: 0 = strap code, 1 = software code |
| strap_code | input | 4 | Frequency code latched from the straps |
| sw_code | input | 4 | Frequency code programmed by software |
| alarm | output | 1 | Expiry status flag |
| sys_rst_n | output | 1 | Active-low system reset pulse |
| revert_pulse | output | 1 | One-cycle strobe after expiry |
| freq_code | output | 4 | Active frequency code |

## Verification
A reload edge and the final tick can fall in the same cycle, and so can a change of the timeout code and a tick. In both cases the block must restart the count rather than expire. The bench runs the count to one tick short of the limit, then raises `reload` in the same cycle as the tick that would expire the timer. It judges the outcome in two ways: the alarm stays low, and the next expiry comes a full limit of ticks later. A behavioural model, checked on every clock, covers the code-change case as well.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef logic [3:0] tsel_t;
    typedef logic [3:0] fcode_t;

    localparam tsel_t TSEL_OFF  = 4'h0;
    localparam tsel_t TSEL_FAST = 4'h1;

    // Per-cycle decisions of the timeout counter
    typedef struct packed {
        logic restart;
        logic advance;
        logic expire;
    } wdt_evt_t;

    // Limit in ticks for a timeout code; 0 means disabled
    function automatic int unsigned timeout_ticks(tsel_t sel, int unsigned tps,
                                                  int unsigned fast);
        if (sel == TSEL_OFF)  return 0;
        if (sel == TSEL_FAST) return fast;
        return 2 * int'(sel) * tps;
    endfunction

endpackage

// File: rtl/wdt_timeout_ctr.sv
module wdt_timeout_ctr
    import wdt_pkg::*;
#(
    parameter int unsigned TICKS_PER_SEC = 1000,
    parameter int unsigned FAST_TICKS    = 10,
    parameter int unsigned CNT_W         = 15
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  ms_tick,
    input  tsel_t tmo_sel,
    input  logic  reload,
    output logic  expire,
    output logic  alarm
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;
    tsel_t            tsel_q;
    logic             reload_q;
    wdt_evt_t         evt;

    always_comb begin
        limit       = CNT_W'(timeout_ticks(tmo_sel, TICKS_PER_SEC, FAST_TICKS));
        evt.restart = (tmo_sel != tsel_q) || (reload && !reload_q);
        evt.advance = (tmo_sel != TSEL_OFF) && !alarm && ms_tick && !evt.restart;
        evt.expire  = evt.advance && (cnt == limit - CNT_W'(1));
    end

    assign expire = evt.expire;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            tsel_q   <= TSEL_OFF;
            reload_q <= 1'b0;
            alarm    <= 1'b0;
        end else begin
            tsel_q   <= tmo_sel;
            reload_q <= reload;
            if (tmo_sel == TSEL_OFF) begin
                alarm <= 1'b0;
                cnt   <= '0;
            end else if (evt.restart) begin
                cnt <= '0;
            end else if (evt.expire) begin
                alarm <= 1'b1;
                cnt   <= '0;
            end else if (evt.advance) begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/wdt_rst_stretch.sv
module wdt_rst_stretch #(
    parameter int unsigned RESET_TICKS = 3,
    localparam int unsigned RW = $clog2(RESET_TICKS + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic ms_tick,
    input  logic fire,
    output logic sys_rst_n
);
    logic [RW-1:0] left;

    always_ff @(posedge clk) begin
        if (rst)
            left <= '0;
        else if (fire)
            left <= RW'(RESET_TICKS);
        else if (ms_tick && left != '0)
            left <= left - RW'(1);
    end

    assign sys_rst_n = (left == '0);
endmodule

// File: rtl/wdt_freq_route.sv
module wdt_freq_route
    import wdt_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   expire,
    input  logic   alarm,
    input  logic   recover_sw,
    input  logic   fs_override,
    input  fcode_t strap_code,
    input  fcode_t sw_code,
    output logic   revert_pulse,
    output fcode_t freq_code
);
    fcode_t fallback;

    always_ff @(posedge clk) begin
        if (rst) begin
            fallback     <= '0;
            revert_pulse <= 1'b0;
        end else begin
            revert_pulse <= expire;
            if (expire)
                fallback <= recover_sw ? sw_code : strap_code;
        end
    end

    always_comb begin
        if (alarm)
            freq_code = fallback;
        else if (fs_override)
            freq_code = sw_code;
        else
            freq_code = strap_code;
    end
endmodule

// File: rtl/wdt_freq_guard.sv
module wdt_freq_guard
    import wdt_pkg::*;
#(
    parameter int unsigned TICKS_PER_SEC      = 1000,
    parameter int unsigned FAST_TIMEOUT_TICKS = 10,
    parameter int unsigned RESET_TICKS        = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ms_tick,
    input  logic [3:0] tmo_sel,
    input  logic       reload,
    input  logic       recover_sw,
    input  logic       fs_override,
    input  logic [3:0] strap_code,
    input  logic [3:0] sw_code,
    output logic       alarm,
    output logic       sys_rst_n,
    output logic       revert_pulse,
    output logic [3:0] freq_code
);
    localparam int unsigned LONGEST = 30 * TICKS_PER_SEC;
    localparam int unsigned MAX_T   = (LONGEST > FAST_TIMEOUT_TICKS) ? LONGEST
                                                                     : FAST_TIMEOUT_TICKS;
    localparam int unsigned CNT_W   = $clog2(MAX_T + 1);

    logic expire;

    wdt_timeout_ctr #(
        .TICKS_PER_SEC(TICKS_PER_SEC),
        .FAST_TICKS   (FAST_TIMEOUT_TICKS),
        .CNT_W        (CNT_W)
    ) u_ctr (
        .clk    (clk),
        .rst    (rst),
        .ms_tick(ms_tick),
        .tmo_sel(tmo_sel),
        .reload (reload),
        .expire (expire),
        .alarm  (alarm)
    );

    wdt_rst_stretch #(.RESET_TICKS(RESET_TICKS)) u_rst (
        .clk      (clk),
        .rst      (rst),
        .ms_tick  (ms_tick),
        .fire     (expire),
        .sys_rst_n(sys_rst_n)
    );

    wdt_freq_route u_route (
        .clk         (clk),
        .rst         (rst),
        .expire      (expire),
        .alarm       (alarm),
        .recover_sw  (recover_sw),
        .fs_override (fs_override),
        .strap_code  (strap_code),
        .sw_code     (sw_code),
        .revert_pulse(revert_pulse),
        .freq_code   (freq_code)
    );
endmodule

// File: rtl/wdt_freq_guard_chk.sv
module wdt_freq_guard_chk (
    input logic       clk,
    input logic       rst,
    input logic       ms_tick,
    input logic [3:0] tmo_sel,
    input logic       reload,
    input logic       alarm,
    input logic       sys_rst_n,
    input logic       revert_pulse,
    input logic [3:0] freq_code
);
    p_alarm_clear_r4: assert property (@(posedge clk) disable iff (rst)
        (tmo_sel == 4'h0) |=> !alarm);

    p_off_no_revert_r2: assert property (@(posedge clk) disable iff (rst)
        (tmo_sel == 4'h0) |=> !revert_pulse);

    p_reset_on_expiry_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(alarm) |-> !sys_rst_n);

    p_pulse_with_alarm_r8: assert property (@(posedge clk) disable iff (rst)
        revert_pulse |-> alarm);

    p_pulse_single_r8: assert property (@(posedge clk) disable iff (rst)
        revert_pulse |=> !revert_pulse);

    p_code_held_r8: assert property (@(posedge clk) disable iff (rst)
        (alarm && $past(alarm)) |-> $stable(freq_code));

    p_expiry_needs_tick_r11: assert property (@(posedge clk) disable iff (rst)
        $rose(alarm) |-> $past(ms_tick));

    p_reload_wins_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(reload) |=> !$rose(alarm));
endmodule

bind wdt_freq_guard wdt_freq_guard_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .ms_tick     (ms_tick),
    .tmo_sel     (tmo_sel),
    .reload      (reload),
    .alarm       (alarm),
    .sys_rst_n   (sys_rst_n),
    .revert_pulse(revert_pulse),
    .freq_code   (freq_code)
);

// File: tb/tb_wdt_freq_guard.sv
module tb_wdt_freq_guard;
    localparam int TPS  = 5;
    localparam int FAST = 10;
    localparam int RSTT = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ms_tick = 1'b0;
    logic [3:0] tmo_sel = 4'h0;
    logic       reload = 1'b0;
    logic       recover_sw = 1'b0;
    logic       fs_override = 1'b0;
    logic [3:0] strap_code = 4'hA;
    logic [3:0] sw_code = 4'h5;
    logic       alarm, sys_rst_n, revert_pulse;
    logic [3:0] freq_code;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    wdt_freq_guard #(
        .TICKS_PER_SEC(TPS), .FAST_TIMEOUT_TICKS(FAST), .RESET_TICKS(RSTT)
    ) dut (
        .clk(clk), .rst(rst), .ms_tick(ms_tick), .tmo_sel(tmo_sel), .reload(reload),
        .recover_sw(recover_sw), .fs_override(fs_override), .strap_code(strap_code),
        .sw_code(sw_code), .alarm(alarm), .sys_rst_n(sys_rst_n),
        .revert_pulse(revert_pulse), .freq_code(freq_code)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Behavioural reference model
    int   m_cnt = 0, m_left = 0, m_tsel_q = 0;
    bit   m_rel_q = 0, m_alarm = 0, m_pulse = 0;
    int   m_fb = 0;

    function automatic int lim(input int s);
        if (s == 0) return 0;
        if (s == 1) return FAST;
        return 2 * s * TPS;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_left = 0; m_tsel_q = 0; m_rel_q = 0;
            m_alarm = 0; m_pulse = 0; m_fb = 0;
        end else begin
            bit rs, adv, ex;
            rs  = (int'(tmo_sel) != m_tsel_q) || (reload && !m_rel_q);
            adv = (tmo_sel != 0) && !m_alarm && ms_tick && !rs;
            ex  = adv && (m_cnt + 1 == lim(int'(tmo_sel)));
            m_pulse = ex;
            if (ex) m_left = RSTT;
            else if (ms_tick && m_left > 0) m_left--;
            if (ex) m_fb = recover_sw ? int'(sw_code) : int'(strap_code);
            if (tmo_sel == 0) begin m_alarm = 0; m_cnt = 0; end
            else if (rs) m_cnt = 0;
            else if (ex) begin m_alarm = 1; m_cnt = 0; end
            else if (adv) m_cnt++;
            m_tsel_q = int'(tmo_sel);
            m_rel_q  = reload;
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            int ef;
            ef = m_alarm ? m_fb : (fs_override ? int'(sw_code) : int'(strap_code));
            check("R4", "model alarm", int'(alarm), int'(m_alarm));
            check("R7", "model sys_rst_n", int'(sys_rst_n), (m_left == 0) ? 1 : 0);
            check("R8", "model revert_pulse", int'(revert_pulse), int'(m_pulse));
            check("R9", "model freq_code", int'(freq_code), ef);
        end
    end

    // Apply ms_tick = t for n clock edges; returns at negedge + 1
    task automatic cycles(input int n, input bit t);
        for (int i = 0; i < n; i++) begin
            ms_tick = t;
            @(negedge clk); #1;
        end
        ms_tick = 1'b0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst = 1'b0;
        cycles(1, 0);
        // R1 reset state
        check("R1", "alarm", int'(alarm), 0);
        check("R1", "sys_rst_n", int'(sys_rst_n), 1);
        check("R1", "revert_pulse", int'(revert_pulse), 0);
        check("R1", "freq_code", int'(freq_code), 'hA);
        // R9 override selects software code
        fs_override = 1'b1; #1;
        check("R9", "override freq", int'(freq_code), 5);
        // R2 disabled timer
        cycles(60, 1);
        check("R2", "alarm while off", int'(alarm), 0);
        // R3 fast code, R8 revert to strap
        tmo_sel = 4'h1; cycles(1, 0);
        cycles(9, 1);
        check("R3", "alarm before limit", int'(alarm), 0);
        cycles(1, 1);
        check("R3", "alarm at limit", int'(alarm), 1);
        check("R8", "revert_pulse", int'(revert_pulse), 1);
        check("R8", "fallback strap", int'(freq_code), 'hA);
        check("R7", "reset low", int'(sys_rst_n), 0);
        cycles(1, 1);
        check("R8", "pulse one cycle", int'(revert_pulse), 0);
        cycles(1, 1);
        check("R7", "reset still low", int'(sys_rst_n), 0);
        cycles(1, 1);
        check("R7", "reset released", int'(sys_rst_n), 1);
        sw_code = 4'h7; #1;
        check("R8", "code held", int'(freq_code), 'hA);
        // R4 alarm persists, clears on off
        cycles(25, 1);
        check("R4", "alarm held", int'(alarm), 1);
        tmo_sel = 4'h0; cycles(1, 0);
        check("R4", "alarm cleared", int'(alarm), 0);
        check("R9", "freq after clear", int'(freq_code), 7);
        // R11 gaps, R8 revert to software code, R7 gaps in pulse
        recover_sw = 1'b1; tmo_sel = 4'h2; cycles(1, 0);
        cycles(19, 1); cycles(30, 0);
        check("R11", "no count without tick", int'(alarm), 0);
        cycles(1, 1);
        check("R3", "code 2 limit", int'(alarm), 1);
        check("R8", "fallback software", int'(freq_code), 7);
        sw_code = 4'h3; #1;
        check("R8", "sw change ignored", int'(freq_code), 7);
        cycles(5, 0);
        check("R7", "pulse waits for ticks", int'(sys_rst_n), 0);
        cycles(3, 1);
        check("R7", "pulse done", int'(sys_rst_n), 1);
        tmo_sel = 4'h0; cycles(1, 0);
        // R5 reload edge restarts, hold has no effect
        tmo_sel = 4'h2; cycles(1, 0);
        cycles(15, 1);
        reload = 1'b1; cycles(1, 1);
        cycles(19, 1);
        check("R5", "held reload no effect", int'(alarm), 0);
        cycles(1, 1);
        check("R5", "expiry after reload", int'(alarm), 1);
        tmo_sel = 4'h0; reload = 1'b0; cycles(RSTT + 1, 1);
        // R6 code change restarts with new limit
        tmo_sel = 4'h2; cycles(1, 0);
        cycles(15, 1);
        tmo_sel = 4'hF; cycles(1, 1);
        cycles(149, 1);
        check("R6", "new limit not yet", int'(alarm), 0);
        cycles(1, 1);
        check("R6", "code 15 limit", int'(alarm), 1);
        tmo_sel = 4'h0; cycles(RSTT + 1, 1);
        // R10 reload on the final tick wins
        tmo_sel = 4'h1; cycles(1, 0);
        cycles(9, 1);
        reload = 1'b1; cycles(1, 1);
        check("R10", "no expiry on reload", int'(alarm), 0);
        check("R10", "no reset on reload", int'(sys_rst_n), 1);
        cycles(9, 1);
        check("R10", "full window again", int'(alarm), 0);
        cycles(1, 1);
        check("R10", "later expiry", int'(alarm), 1);
        cycles(4, 0);
        finish_run();
    end
endmodule